// File: doc/BRIEF.md
# Receive Half-Bit Clock Recovery Counter

This block recovers a sampling instant for an incoming 64 kbit/s codirectional line signal. It runs on a free-running reference clock at nominally 2.048 MHz. A phase counter divides that reference by a nominal 16, which gives a 128 kHz half-bit rate. The two active-high mark rails from a line receiver pass through a two-flop synchronizer. A rising edge on either rail counts as a data transition, and a transition pulls the counter into phase. The block emits a one-cycle enable at the middle of each half-bit and a lock flag. A decoder downstream uses the enable to sample the rails.

The control is a two-state machine. In SEEK the counter runs a short cycle of 8 reference clocks and waits for any transition. The transition named ACQUIRE moves SEEK to LOCK: the first detected transition places the counter at phase 1. In LOCK the counter runs a cycle of 16. A transition one cycle early or one cycle late snaps the phase, which shortens that count to 15 or stretches it to 17. Transitions that land outside this three-cycle window are ignored. The transition named LOSE moves LOCK back to SEEK when 16 consecutive sampling instants pass with no transition inside the window.

Top module: `rxclk_recover`

## Requirements
- R1: While reset is held and in the first cycle after its release, `locked` is 0 and `sample_en` is 0. The block leaves reset in SEEK with the counter at phase 0.
- R2: In SEEK with no transitions, `sample_en` pulses for one cycle every 8 reference cycles, at counter phase 4.
- R3: A rising level on `mark_pos` or `mark_neg` is a transition. It is acted on at the third rising clock edge after the input changes, which accounts for two synchronizer flops and one edge-history flop. In SEEK a transition sets `locked` to 1 and places the counter at phase 1.
- R4: In LOCK, `sample_en` pulses for exactly one cycle at counter phase 8. With transitions arriving at phase 0, successive pulses are 16 cycles apart.
- R5: In LOCK, a transition seen at phase 1 (one cycle late) holds the counter at phase 1 for one more cycle. The enable spacing across it becomes 17.
- R6: In LOCK, a transition seen at phase 15 (one cycle early) moves the counter straight to phase 1. The enable spacing across it becomes 15.
- R7: In LOCK, a transition seen at any phase from 2 to 14 does not change the counter or the lock, and the enable spacing stays 16.
- R8: In LOCK, if 16 consecutive sampling instants pass with no transition in the window {15, 0, 1}, then `locked` drops after the 16th instant. The counter restarts at phase 0 in SEEK, and the 8-cycle spacing follows.
- R9: A steady high level and a falling edge on a rail are not transitions. Neither of them causes ACQUIRE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock, nominally 2.048 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| mark_pos | input | 1 | Positive mark rail, active high, asynchronous |
| mark_neg | input | 1 | Negative mark rail, active high, asynchronous |
| sample_en | output | 1 | One-cycle enable at the middle of each recovered half-bit |
| locked | output | 1 | High while the recovery counter is in LOCK |

## Verification
The recovered phase is visible at the ports only through the spacing of `sample_en`. A corrupted counter value therefore shows up as a wrong gap at the very next enable, within at most 17 reference cycles. A corrupted miss count or state stays hidden until the lock flag moves. It shows as a `locked` edge at the wrong sampling instant, up to 16 half-bits later. For this reason the bench compares both outputs against an independent cycle model on every clock. It also times the enable gaps around early, late, on-time and off-window transitions.

// File: rtl/rxclk_pkg.sv
package rxclk_pkg;
    typedef enum logic {
        ST_SEEK = 1'b0,
        ST_LOCK = 1'b1
    } rec_state_e;
endpackage

// File: rtl/rxclk_edge.sv
// Synchronizes each mark rail and flags a rising level on any of them.
module rxclk_edge #(
    parameter int RAILS       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RAILS-1:0] rail_i,
    output logic             trans_o
);
    logic [RAILS-1:0] rise;

    for (genvar g = 0; g < RAILS; g++) begin : g_rail
        // stages [SYNC_STAGES-1:0] synchronize, the top bit is edge history
        logic [SYNC_STAGES:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[SYNC_STAGES-1:0], rail_i[g]};
        end
        assign rise[g] = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
    end

    assign trans_o = |rise;
endmodule

// File: rtl/rxclk_phase.sv
// Variable-length phase counter with SEEK / LOCK control.
module rxclk_phase
    import rxclk_pkg::*;
#(
    parameter int PERIOD     = 16,
    parameter int SEEK_LEN   = 8,
    parameter int MISS_LIMIT = 16,
    localparam int CW = $clog2(PERIOD),
    localparam int MW = $clog2(MISS_LIMIT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trans_i,
    output logic [CW-1:0] cnt_o,
    output logic [MW-1:0] miss_o,
    output logic          sample_en_o,
    output logic          locked_o
);
    localparam logic [CW-1:0] PH_ZERO   = '0;
    localparam logic [CW-1:0] PH_ONE    = CW'(1);
    localparam logic [CW-1:0] PH_LAST   = CW'(PERIOD - 1);
    localparam logic [CW-1:0] PH_SAMPLE = CW'(PERIOD / 2);
    localparam logic [CW-1:0] SK_LAST   = CW'(SEEK_LEN - 1);
    localparam logic [CW-1:0] SK_SAMPLE = CW'(SEEK_LEN / 2);
    localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);

    rec_state_e    state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [MW-1:0] miss, miss_n;
    logic          in_window;

    assign in_window = trans_i &&
                       (cnt == PH_ZERO || cnt == PH_ONE || cnt == PH_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SEEK;
            cnt   <= PH_ZERO;
            miss  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            miss  <= miss_n;
        end
    end

    // next state: ACQUIRE (SEEK->LOCK), LOSE (LOCK->SEEK)
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        miss_n  = miss;
        unique case (state)
            ST_SEEK: begin
                if (trans_i) begin
                    state_n = ST_LOCK;
                    cnt_n   = PH_ONE;
                    miss_n  = '0;
                end else begin
                    cnt_n = (cnt == SK_LAST) ? PH_ZERO : cnt + PH_ONE;
                end
            end
            ST_LOCK: begin
                if (in_window) begin
                    cnt_n  = PH_ONE;
                    miss_n = '0;
                end else if (cnt == PH_SAMPLE) begin
                    if (miss == MISS_LAST) begin
                        state_n = ST_SEEK;
                        cnt_n   = PH_ZERO;
                        miss_n  = '0;
                    end else begin
                        miss_n = miss + MW'(1);
                        cnt_n  = cnt + PH_ONE;
                    end
                end else begin
                    cnt_n = (cnt == PH_LAST) ? PH_ZERO : cnt + PH_ONE;
                end
            end
            default: begin
                state_n = ST_SEEK;
                cnt_n   = PH_ZERO;
                miss_n  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_LOCK: sample_en_o = (cnt == PH_SAMPLE);
            default: sample_en_o = (cnt == SK_SAMPLE);
        endcase
        locked_o = (state == ST_LOCK);
    end

    assign cnt_o  = cnt;
    assign miss_o = miss;
endmodule

// File: rtl/rxclk_recover.sv
module rxclk_recover #(
    parameter int PERIOD      = 16,
    parameter int SEEK_LEN    = 8,
    parameter int MISS_LIMIT  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_pos,
    input  logic mark_neg,
    output logic sample_en,
    output logic locked
);
    localparam int CW = $clog2(PERIOD);
    localparam int MW = $clog2(MISS_LIMIT);

    logic          trans_w;
    logic [CW-1:0] cnt_w;
    logic [MW-1:0] miss_w;

    rxclk_edge #(.RAILS(2), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .rail_i ({mark_neg, mark_pos}),
        .trans_o(trans_w)
    );

    rxclk_phase #(.PERIOD(PERIOD), .SEEK_LEN(SEEK_LEN), .MISS_LIMIT(MISS_LIMIT)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .trans_i    (trans_w),
        .cnt_o      (cnt_w),
        .miss_o     (miss_w),
        .sample_en_o(sample_en),
        .locked_o   (locked)
    );
endmodule

// File: rtl/rxclk_recover_chk.sv
module rxclk_recover_chk #(
    parameter int PERIOD     = 16,
    parameter int SEEK_LEN   = 8,
    parameter int MISS_LIMIT = 16,
    localparam int CW = $clog2(PERIOD),
    localparam int MW = $clog2(MISS_LIMIT)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trans,
    input logic [CW-1:0] cnt,
    input logic [MW-1:0] miss,
    input logic          locked,
    input logic          sample_en
);
    a_r2_seek_range: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> int'(cnt) < SEEK_LEN);

    a_r3_acquire: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && trans) |=> (locked && int'(cnt) == 1));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> !sample_en);

    a_r5_late_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && trans && int'(cnt) == 1) |=> (locked && int'(cnt) == 1));

    a_r6_early_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && trans && int'(cnt) == PERIOD - 1) |=> (locked && int'(cnt) == 1));

    a_r7_ignore_off_window: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && trans && int'(cnt) > 1 && int'(cnt) < PERIOD - 1 && int'(cnt) != PERIOD / 2)
        |=> (locked && int'(cnt) == int'($past(cnt)) + 1));

    a_r8_lose_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> (int'($past(miss)) == MISS_LIMIT - 1 &&
                           int'($past(cnt)) == PERIOD / 2 && int'(cnt) == 0));
endmodule

bind rxclk_recover rxclk_recover_chk #(
    .PERIOD(PERIOD), .SEEK_LEN(SEEK_LEN), .MISS_LIMIT(MISS_LIMIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trans    (trans_w),
    .cnt      (cnt_w),
    .miss     (miss_w),
    .locked   (locked),
    .sample_en(sample_en)
);

// File: tb/rxclk_recover_test.sv
module rxclk_recover_test;
    localparam int P    = 16;
    localparam int SK   = 8;
    localparam int MISS = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic mp = 0, mn = 0;
    logic sample_en, locked;

    always #5 clk = ~clk;

    rxclk_recover uut (
        .clk(clk), .rst_n(rst_n), .mark_pos(mp), .mark_neg(mn),
        .sample_en(sample_en), .locked(locked)
    );

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit done = 0;

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---- independent cycle model of the requirements ----
    int m_cnt = 0, m_miss = 0;
    bit m_lock = 0;
    bit s1p, s2p, dp, s1n, s2n, dn;
    always @(posedge clk) begin
        bit t;
        if (!rst_n) begin
            m_cnt = 0; m_miss = 0; m_lock = 0;
            s1p = 0; s2p = 0; dp = 0; s1n = 0; s2n = 0; dn = 0;
        end else begin
            t = (s2p & ~dp) | (s2n & ~dn);
            dp = s2p; s2p = s1p; s1p = mp;
            dn = s2n; s2n = s1n; s1n = mn;
            if (!m_lock) begin
                if (t) begin m_lock = 1; m_cnt = 1; m_miss = 0; end
                else m_cnt = (m_cnt + 1) % SK;
            end else if (t && (m_cnt == 0 || m_cnt == 1 || m_cnt == P - 1)) begin
                m_cnt = 1; m_miss = 0;
            end else if (m_cnt == P / 2) begin
                if (m_miss == MISS - 1) begin m_lock = 0; m_cnt = 0; m_miss = 0; end
                else begin m_miss++; m_cnt++; end
            end else m_cnt = (m_cnt + 1) % P;
        end
    end

    function automatic bit exp_en(input bit lk, input int c);
        return lk ? (c == P / 2) : (c == SK / 2);
    endfunction

    always @(negedge clk) if (rst_n && !done) begin
        check(cur_req, sample_en, exp_en(m_lock, m_cnt), "sample_en vs model");
        check(cur_req, locked, m_lock, "locked vs model");
    end

    // ---- enable gap monitor ----
    int cyc = 0, last_t = 0, last_gap = 0;
    always @(posedge clk) begin
        cyc++;
        if (rst_n && sample_en) begin last_gap = cyc - last_t; last_t = cyc; end
    end

    task automatic wait_en();
        @(negedge clk);
        while (!sample_en) @(negedge clk);
        @(negedge clk);
    endtask

    // drive a rise so that it is acted on at counter phase t (in LOCK)
    task automatic hit(input bit neg, input int t);
        int at = (t - 2 + P) % P;
        @(negedge clk);
        while (!(m_lock && m_cnt == at)) @(negedge clk);
        if (neg) mn = 1; else mp = 1;
        repeat (3) @(negedge clk);
        mp = 0; mn = 0;
    endtask

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        check("R1", locked, 0, "locked in reset");
        check("R1", sample_en, 0, "sample_en in reset");
        rst_n = 1;
        @(negedge clk);
        check("R1", locked, 0, "locked after reset");
        check("R1", sample_en, 0, "sample_en after reset");

        cur_req = "R2";
        wait_en(); wait_en();
        check("R2", last_gap, SK, "seek enable gap");

        cur_req = "R3";
        mp = 1;
        repeat (2) @(negedge clk);
        check("R3", locked, 0, "locked before third edge");
        @(negedge clk);
        check("R3", locked, 1, "locked after pos rise");
        mp = 0;

        cur_req = "R4";
        for (int i = 0; i < 3; i++) begin
            hit(0, 0); wait_en();
            check("R4", last_gap, P, "on-time gap");
        end
        cur_req = "R5";
        hit(0, 1); wait_en();
        check("R5", last_gap, P + 1, "late gap");
        cur_req = "R6";
        hit(1, P - 1); wait_en();
        check("R6", last_gap, P - 1, "early gap");
        cur_req = "R7";
        hit(0, 5); wait_en();
        check("R7", last_gap, P, "off-window gap");
        check("R7", locked, 1, "lock kept");
        hit(1, 12); wait_en();
        check("R7", last_gap, P, "off-window gap neg rail");

        cur_req = "R8";
        hit(0, 0);
        n = 0;
        forever begin
            @(negedge clk);
            if (!locked) break;
            if (sample_en) n++;
        end
        check("R8", n, MISS, "instants before lose");
        wait_en(); wait_en();
        check("R8", last_gap, SK, "seek gap after lose");

        cur_req = "R3";
        mn = 1;
        repeat (3) @(negedge clk);
        check("R3", locked, 1, "locked after neg rise");

        cur_req = "R9";
        hit(0, 0);
        mp = 1;   // hold high after an on-time rise
        while (locked) @(negedge clk);
        repeat (40) @(negedge clk);
        check("R9", locked, 0, "steady high ignored");
        mp = 0; mn = 0;
        repeat (20) @(negedge clk);
        check("R9", locked, 0, "falling edge ignored");

        cur_req = "R4";
        for (int i = 0; i < 300; i++) begin
            int lo = 3 + ($urandom % 30);
            int hi = 2 + ($urandom % 4);
            bit r = 1'($urandom % 2);
            repeat (lo) @(negedge clk);
            if (r) mn = 1; else mp = 1;
            repeat (hi) @(negedge clk);
            mp = 0; mn = 0;
        end
        repeat (30) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule